// File: doc/BRIEF.md
# Write-Zero-Clear Interrupt Flag Unit

This block collects the interrupt events of a low-speed bus device controller with keyboard and mouse wake sources. It keeps them in two flag groups and drives one active-low request line per group towards the CPU. Each event input that is high in a cycle sets its flag at the next clock edge. The flag then holds until software writes a 0 into that bit position of the group's clear register. Writing a 1 leaves the bit alone, so a read-modify-write is never needed to acknowledge one event without losing another.

Three of the events are produced inside the block. A keyboard wake is a low level on any scan input that is not masked. A mouse wake is a low level on the mouse clock pin. Both pin inputs pass through a reset-to-high synchronizer first. A suspend event is raised by an idle timer once the bus has shown no activity for a parameterised number of clock cycles. A resume event is accepted only while the interface reports that it is suspended.

Software writes through a single strobe with a 3-bit select and an 8-bit data word. The current flag vectors are presented on output ports.

Top module: `wzc_irq_unit`

## Requirements
- R1: A write with select 0 (group 0) or select 1 (group 1) clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged, taking effect at the clock edge of the write.
- R2: `irq0_no` is low exactly when some group 0 flag is set and its enable bit is set. `irq1_no` follows the same rule for group 1. Both are combinational from the flag and enable registers.
- R3: Group 0 bit positions are: 0 endpoint 0 receive, 1 endpoint 0 transmit, 2 endpoint 1 transmit, 3 endpoint 2 transmit, 4 bus reset, 5 suspend. Group 1 bit positions are: 0 resume, 1 keyboard, 2 mouse. An event input high during a cycle sets its flag at the next rising edge.
- R4: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The keyboard flag sets when any synchronized scan input is low and its mask bit is 0. A mask bit of 1 blocks that input. Scan inputs pass through SYNC_STAGES flops that reset to 1, so a low level sets the flag SYNC_STAGES+1 edges after it is sampled.
- R6: The mouse flag sets when the synchronized mouse clock input is low, with the same synchronizer delay as R5.
- R7: After IDLE_CYCLES consecutive cycles with `bus_active_i` low, counted from reset or from the last active cycle, the suspend flag sets once. Any active cycle restarts the count. A long idle stretch produces only one set event.
- R8: The resume flag sets only in a cycle where `resume_sig_i` and `suspended_i` are both high.
- R9: Reset clears all flags, enables and mask bits, and holds both request outputs high.
- R10: Select 2 loads the group 0 enables from data bits 5:0, select 3 loads the group 1 enables from bits 2:0, and select 4 loads the scan mask. Selects 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (0 clr0, 1 clr1, 2 en0, 3 en1, 4 mask) |
| wr_data_i | input | 8 | Write data |
| ep0_rx_done_i | input | 1 | Endpoint 0 receive complete event |
| ep0_tx_done_i | input | 1 | Endpoint 0 transmit acknowledged event |
| ep1_tx_done_i | input | 1 | Endpoint 1 transmit acknowledged event |
| ep2_tx_done_i | input | 1 | Endpoint 2 transmit acknowledged event |
| bus_reset_i | input | 1 | Bus reset detected event |
| bus_active_i | input | 1 | Bus activity seen this cycle |
| resume_sig_i | input | 1 | Resume signalling seen on the bus |
| suspended_i | input | 1 | Interface currently suspended |
| ksi_i | input | 8 | Asynchronous key scan inputs |
| ms_clk_i | input | 1 | Asynchronous mouse clock pin |
| flags0_o | output | 6 | Group 0 flags |
| flags1_o | output | 3 | Group 1 flags |
| irq0_no | output | 1 | Group 0 interrupt request, active low |
| irq1_no | output | 1 | Group 1 interrupt request, active low |

## Verification
The bench targets the cycle where an event and a clearing write coincide. A design that lets the clear win there drops that event for good. The bench also writes a mix of ones and zeros to show that ones preserve flags; a design that loads the data word would raise flags that never had an event. Scan inputs are driven low on masked and unmasked bits, and one is held low through a clear, so that a flipped mask polarity or an edge-only detector shows up. The idle timer is interrupted just short of its limit and then left idle far beyond it: a timer that fails to restart on activity, or one that fires again while idle, puts the suspend flag back after software has cleared it.

// File: rtl/wzc_irq_pkg.sv
package wzc_irq_pkg;
  localparam int G0_W = 6;
  localparam int G1_W = 3;
  localparam int DW   = 8;

  // group 0 bit positions
  localparam int B0_EP0_RX = 0;
  localparam int B0_EP0_TX = 1;
  localparam int B0_EP1_TX = 2;
  localparam int B0_EP2_TX = 3;
  localparam int B0_BRST   = 4;
  localparam int B0_SUSP   = 5;
  // group 1 bit positions
  localparam int B1_RSM    = 0;
  localparam int B1_KBD    = 1;
  localparam int B1_MS     = 2;

  typedef enum logic [2:0] {
    SEL_CLR0  = 3'd0,
    SEL_CLR1  = 3'd1,
    SEL_EN0   = 3'd2,
    SEL_EN1   = 3'd3,
    SEL_KMASK = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= {W{RST_V}};
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_idle_timer.sv
module irq_idle_timer #(
  parameter int IDLE_CYCLES = 150000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic evt_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);
  localparam logic [CW-1:0] LAST  = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (active_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;  // saturate: one event per idle stretch
  end

  assign evt_o = !active_i && (cnt_q == LAST);

  initial begin
    if (IDLE_CYCLES < 2) $error("IDLE_CYCLES must be at least 2");
  end

  // R7: a single idle stretch never yields back-to-back events
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
  // R7: activity restarts the count, so no event right after it
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |=> !evt_o);
endmodule

// File: rtl/irq_wake_detect.sv
module irq_wake_detect #(
  parameter int KW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_we_i,
  input  logic [KW-1:0] mask_d_i,
  input  logic [KW-1:0] ksi_s_i,
  input  logic          ms_s_i,
  output logic          kbd_evt_o,
  output logic          ms_evt_o
);
  logic [KW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign kbd_evt_o = |(~ksi_s_i & ~mask_q);
  assign ms_evt_o  = !ms_s_i;

  // R5: fully masked scan inputs raise nothing
  a_r5_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !kbd_evt_o);
  // R5: all inputs high raise nothing
  a_r5_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&ksi_s_i) |-> !kbd_evt_o);
endmodule

// File: rtl/irq_flag_group.sv
module irq_flag_group #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flags_o,
  output logic         irq_no
);
  logic [W-1:0] flags_q, en_q, keep;

  assign keep = clr_we_i ? wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & keep) | set_i;  // set wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= wdata_i;
  end

  assign flags_o = flags_q;
  assign irq_no  = ~|(flags_q & en_q);

  // R1: zero bits clear flags that had no set event
  a_r1_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((~$past(wdata_i) & ~$past(set_i) & flags_q) == '0));
  // R1: one bits keep flags
  a_r1_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (($past(flags_q) & $past(wdata_i) & ~flags_q) == '0));
  // R4: every set event lands, whatever the write did
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> (($past(set_i) & ~flags_q) == '0));
  // R2: enabled event pulls the request low
  a_r2_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(set_i & en_q)) && !en_we_i) |=> !irq_no);
  // R9: no flag can be present without a prior event after reset
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && flags_q == '0) |=> (flags_q == '0));
endmodule

// File: rtl/wzc_irq_unit.sv
module wzc_irq_unit
  import wzc_irq_pkg::*;
#(
  parameter int KSI_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 150000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             ep0_rx_done_i,
  input  logic             ep0_tx_done_i,
  input  logic             ep1_tx_done_i,
  input  logic             ep2_tx_done_i,
  input  logic             bus_reset_i,
  input  logic             bus_active_i,
  input  logic             resume_sig_i,
  input  logic             suspended_i,
  input  logic [KSI_W-1:0] ksi_i,
  input  logic             ms_clk_i,
  output logic [G0_W-1:0]  flags0_o,
  output logic [G1_W-1:0]  flags1_o,
  output logic             irq0_no,
  output logic             irq1_no
);
  logic             we_clr0, we_clr1, we_en0, we_en1, we_mask;
  logic [KSI_W-1:0] ksi_s;
  logic             ms_s, kbd_evt, ms_evt, susp_evt, rsm_evt;
  logic [G0_W-1:0]  set0;
  logic [G1_W-1:0]  set1;

  assign we_clr0 = wr_en_i && (wr_sel_i == SEL_CLR0);
  assign we_clr1 = wr_en_i && (wr_sel_i == SEL_CLR1);
  assign we_en0  = wr_en_i && (wr_sel_i == SEL_EN0);
  assign we_en1  = wr_en_i && (wr_sel_i == SEL_EN1);
  assign we_mask = wr_en_i && (wr_sel_i == SEL_KMASK);

  irq_sync #(.W(KSI_W), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_ksi_sync (
    .clk_i, .rst_ni, .d_i(ksi_i), .q_o(ksi_s));

  irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_ms_sync (
    .clk_i, .rst_ni, .d_i(ms_clk_i), .q_o(ms_s));

  irq_wake_detect #(.KW(KSI_W)) u_wake (
    .clk_i, .rst_ni,
    .mask_we_i(we_mask), .mask_d_i(wr_data_i[KSI_W-1:0]),
    .ksi_s_i(ksi_s), .ms_s_i(ms_s),
    .kbd_evt_o(kbd_evt), .ms_evt_o(ms_evt));

  irq_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i, .rst_ni, .active_i(bus_active_i), .evt_o(susp_evt));

  assign rsm_evt = resume_sig_i && suspended_i;

  always_comb begin
    set0            = '0;
    set0[B0_EP0_RX] = ep0_rx_done_i;
    set0[B0_EP0_TX] = ep0_tx_done_i;
    set0[B0_EP1_TX] = ep1_tx_done_i;
    set0[B0_EP2_TX] = ep2_tx_done_i;
    set0[B0_BRST]   = bus_reset_i;
    set0[B0_SUSP]   = susp_evt;
    set1            = '0;
    set1[B1_RSM]    = rsm_evt;
    set1[B1_KBD]    = kbd_evt;
    set1[B1_MS]     = ms_evt;
  end

  irq_flag_group #(.W(G0_W)) u_grp0 (
    .clk_i, .rst_ni, .set_i(set0), .clr_we_i(we_clr0), .en_we_i(we_en0),
    .wdata_i(wr_data_i[G0_W-1:0]), .flags_o(flags0_o), .irq_no(irq0_no));

  irq_flag_group #(.W(G1_W)) u_grp1 (
    .clk_i, .rst_ni, .set_i(set1), .clr_we_i(we_clr1), .en_we_i(we_en1),
    .wdata_i(wr_data_i[G1_W-1:0]), .flags_o(flags1_o), .irq_no(irq1_no));

  // R8: resume flag only rises after a resume seen while suspended
  a_r8_resume_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags1_o[B1_RSM]) |-> $past(suspended_i && resume_sig_i));
  // R10: unused selects leave group 0 flags untouched when no event
  a_r10_unused_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i > 3'd4 && set0 == '0) |=> $stable(flags0_o));
endmodule

// File: tb/wzc_irq_unit_bench.sv
module wzc_irq_unit_bench;
  localparam int IDLE = 40;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic ep0_rx = 0, ep0_tx = 0, ep1_tx = 0, ep2_tx = 0, brst = 0;
  logic bus_active = 1, resume_sig = 0, suspended = 0, ms_clk = 1;
  logic [7:0] ksi = 8'hff;
  logic [5:0] flags0;
  logic [2:0] flags1;
  logic irq0_n, irq1_n;

  always #10 clk = ~clk;  // 50 MHz

  wzc_irq_unit #(.KSI_W(8), .SYNC_STAGES(SYNC), .IDLE_CYCLES(IDLE)) u_wzc_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ep0_rx_done_i(ep0_rx), .ep0_tx_done_i(ep0_tx), .ep1_tx_done_i(ep1_tx),
    .ep2_tx_done_i(ep2_tx), .bus_reset_i(brst), .bus_active_i(bus_active),
    .resume_sig_i(resume_sig), .suspended_i(suspended), .ksi_i(ksi), .ms_clk_i(ms_clk),
    .flags0_o(flags0), .flags1_o(flags1), .irq0_no(irq0_n), .irq1_no(irq1_n));

  // behavioural reference
  logic [5:0] m_f0, m_e0, s0;
  logic [2:0] m_f1, m_e1, s1;
  logic [7:0] m_mask, ksv;
  logic       msv;
  int         m_idle;
  logic [7:0] kq[$];
  logic       mq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f0 = 0; m_e0 = 0; m_f1 = 0; m_e1 = 0; m_mask = 0; m_idle = 0;
      kq = {}; mq = {};
      for (int i = 0; i < SYNC; i++) begin kq.push_back(8'hff); mq.push_back(1'b1); end
    end else begin
      ksv = kq.pop_front(); kq.push_back(ksi);
      msv = mq.pop_front(); mq.push_back(ms_clk);
      s0 = {(!bus_active && m_idle == IDLE - 1), brst, ep2_tx, ep1_tx, ep0_tx, ep0_rx};
      s1 = {!msv, (ksv | m_mask) != 8'hff, resume_sig && suspended};
      if (bus_active) m_idle = 0;
      else if (m_idle < IDLE) m_idle++;
      if (wr_en && wr_sel == 3'd0) m_f0 = m_f0 & wr_data[5:0];
      if (wr_en && wr_sel == 3'd1) m_f1 = m_f1 & wr_data[2:0];
      if (wr_en && wr_sel == 3'd2) m_e0 = wr_data[5:0];
      if (wr_en && wr_sel == 3'd3) m_e1 = wr_data[2:0];
      if (wr_en && wr_sel == 3'd4) m_mask = wr_data;
      m_f0 = m_f0 | s0;
      m_f1 = m_f1 | s1;
    end
  end

  int n_cmp = 0, n_bad = 0;
  string phase = "R9";
  bit done = 0;

  always @(negedge clk) begin
    if (!done) begin
      logic [11:0] act, exp_v;
      act   = {flags0, flags1, irq0_n, irq1_n, 1'b0};
      exp_v = {m_f0, m_f1, !(|(m_f0 & m_e0)), !(|(m_f1 & m_e1)), 1'b0};
      n_cmp++;
      if (act !== exp_v) begin
        n_bad++;
        $display("FAIL %s: f0=%h f1=%h irq0_n=%b irq1_n=%b, expected f0=%h f1=%h irq0_n=%b irq1_n=%b",
          phase, flags0, flags1, irq0_n, irq1_n, exp_v[11:6], exp_v[5:3], exp_v[2], exp_v[1]);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    tick(1);
    wr_en = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    phase = "R9"; tick(3);

    phase = "R10"; wr(3'd2, 8'h3f); wr(3'd3, 8'h07); tick(1);

    phase = "R3";
    ep0_rx = 1; tick(1); ep0_rx = 0; tick(2);
    ep0_tx = 1; tick(1); ep0_tx = 0; tick(2);
    ep1_tx = 1; tick(1); ep1_tx = 0; tick(2);
    ep2_tx = 1; tick(1); ep2_tx = 0; tick(2);
    brst = 1;   tick(1); brst = 0;   tick(2);

    phase = "R1";
    wr(3'd0, 8'h2a); tick(2);
    wr(3'd0, 8'hff); tick(1);
    wr(3'd0, 8'h00); tick(2);

    phase = "R4";
    ep1_tx = 1; wr(3'd0, 8'h00); ep1_tx = 0; tick(2);
    ep0_rx = 1; brst = 1; wr(3'd0, 8'h10); ep0_rx = 0; brst = 0; tick(2);
    wr(3'd0, 8'h00);

    phase = "R2";
    wr(3'd2, 8'h04);
    ep0_rx = 1; tick(1); ep0_rx = 0; tick(2);
    ep1_tx = 1; tick(1); ep1_tx = 0; tick(2);
    wr(3'd0, 8'h00); wr(3'd2, 8'h3f); tick(1);

    phase = "R5";
    wr(3'd4, 8'hf0);
    ksi = 8'h7f; tick(5); ksi = 8'hff; tick(3);
    ksi = 8'hfb; tick(5); ksi = 8'hff; tick(4);
    wr(3'd1, 8'h00);
    ksi = 8'hfe; tick(4); wr(3'd1, 8'h00); tick(2);
    ksi = 8'hff; tick(4); wr(3'd1, 8'h00); tick(1);

    phase = "R6";
    ms_clk = 0; tick(4); ms_clk = 1; tick(4);
    wr(3'd1, 8'h00); tick(1);

    phase = "R8";
    resume_sig = 1; tick(2); resume_sig = 0; tick(1);
    suspended = 1; tick(2); resume_sig = 1; tick(1);
    resume_sig = 0; suspended = 0; tick(2);
    wr(3'd1, 8'h00); tick(1);

    phase = "R7";
    bus_active = 0; tick(IDLE - 3); bus_active = 1; tick(1);
    bus_active = 0; tick(IDLE + 20);
    wr(3'd0, 8'h00); tick(IDLE);
    bus_active = 1; tick(2); wr(3'd0, 8'h00); tick(1);

    phase = "R10";
    ep0_rx = 1; tick(1); ep0_rx = 0;
    wr(3'd5, 8'h00); wr(3'd6, 8'h00); wr(3'd7, 8'h00); tick(1);
    wr(3'd2, 8'h00); tick(1);
    wr(3'd4, 8'hff); ksi = 8'h00; tick(5); ksi = 8'hff; tick(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule